// File: doc/BRIEF.md
# Dual 8-bit General-Purpose I/O Port

This block gives a processor two memory-mapped, byte-wide general-purpose I/O ports. Each port has an output latch and a direction register. Each bit of the direction register makes its pin an output (1) or an input (0). A simple register interface is used: an address, a write enable, a read enable, write data and read data. The pin side is kept as separate output-value, output-enable and input buses, so the pad ring outside the block builds the actual tri-state drivers.

Software writes a data register to set what the output pins drive. A write always lands in the latch, even for pins that are currently inputs, so a value can be preloaded before the pin is turned around. Reading a data register returns a per-bit mix: output bits show the latch, and input bits show the pin after a two-flop synchronizer. Reset clears the direction registers only. Every pin therefore comes up as an input, and the latch contents survive.

Top module: `gpio_dual_port`

## Requirements
- R1: For every bit, `pin_oe` equals the direction bit, and `pin_out` equals the output latch bit whether or not the pin is enabled.
- R2: While `rst` is high, all direction bits clear to 0, so `pin_oe` is all zeros after reset. The held read address resets to 0x00 and the synchronizers to 0, so `rd_data` reads 0x00 right after reset.
- R3: Reset does not change the output latches. A value written before reset is still on `pin_out` after it.
- R4: A write to a data register updates that port's latch on the clock edge where `wr_en` is high, even if every bit of that port is an input. The write does not change `pin_oe`.
- R5: A read of a data register returns, per bit, the latch when the direction bit is 1 and the synchronized pin when it is 0.
- R6: A pin value present at `pin_in` before clock edge k appears on `rd_data` after edge k+1 (two-flop synchronizer), and not after edge k alone.
- R7: The direction registers can be written and read back at their own addresses.
- R8: Reads of unmapped addresses return 0x00. Writes to unmapped addresses change no latch and no direction bit.
- R9: Address map: port A data 0x00, port B data 0x01, port A direction 0x04, port B direction 0x05. Port A uses bits 7:0 of the pin buses and port B uses bits 15:8.
- R10: `rd_en` registers the address. `rd_data` is then combinational from that held address and follows later changes of the selected register without a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address for reads and writes |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable; captures `addr` as the read address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the held read address |
| pin_in | input | 16 | Raw pin inputs, port A in bits 7:0 |
| pin_out | output | 16 | Output latch values driven towards the pins |
| pin_oe | output | 16 | Per-pin output enable |

## Verification
The hardest case to reach from the ports is a data read where input and output bits are mixed and the pin value changes under a held read address. The check must show the old synchronized value for one cycle and the new one only after the second edge. The bench sets a partial direction mask, holds the read address, changes `pin_in` on a falling edge and samples `rd_data` after each of the next two rising edges. Latch retention is checked by writing a value, pulsing reset and observing `pin_out` together with a cleared `pin_oe`. A random phase then mixes writes, reads, unmapped accesses and pin changes, and compares every cycle against a behavioural model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Direction registers sit this far above the data registers.
  localparam int DIR_OFS = 4;
  localparam int MAX_PORTS = DIR_OFS;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode #(
  parameter int ADDR_W = 8,
  parameter int NP     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NP-1:0]     data_hit,
  output logic [NP-1:0]     dir_hit
);
  import gpio_pkg::*;

  for (genvar i = 0; i < NP; i++) begin : g_hit
    assign data_hit[i] = (addr == ADDR_W'(i));
    assign dir_hit[i]  = (addr == ADDR_W'(DIR_OFS + i));
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] view
);
  logic [W-1:0] sync1_q;
  logic [W-1:0] sync2_q;

  // Output latch: deliberately outside the reset domain.
  always_ff @(posedge clk) begin
    if (data_we) latch_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      if (dir_we) dir_q <= wdata;
      sync1_q <= pin_raw;
      sync2_q <= sync1_q;
    end
  end

  assign view = (dir_q & latch_q) | (~dir_q & sync2_q);
endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port #(
  parameter int ADDR_W    = 8,
  parameter int W         = 8,
  parameter int NUM_PORTS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [W-1:0]           wr_data,
  output logic [W-1:0]           rd_data,
  input  logic [NUM_PORTS*W-1:0] pin_in,
  output logic [NUM_PORTS*W-1:0] pin_out,
  output logic [NUM_PORTS*W-1:0] pin_oe
);
  import gpio_pkg::*;

  localparam int NP = NUM_PORTS;

  logic [ADDR_W-1:0] rd_addr_q;
  logic [NP-1:0]     wr_data_hit, wr_dir_hit;
  logic [NP-1:0]     rd_data_hit, rd_dir_hit;
  logic [W-1:0]      latch_v [NP];
  logic [W-1:0]      dir_v   [NP];
  logic [W-1:0]      view_v  [NP];

  always_ff @(posedge clk) begin
    if (rst)        rd_addr_q <= '0;
    else if (rd_en) rd_addr_q <= addr;
  end

  gpio_addr_decode #(.ADDR_W(ADDR_W), .NP(NP)) u_wr_dec (
    .addr(addr), .data_hit(wr_data_hit), .dir_hit(wr_dir_hit)
  );

  gpio_addr_decode #(.ADDR_W(ADDR_W), .NP(NP)) u_rd_dec (
    .addr(rd_addr_q), .data_hit(rd_data_hit), .dir_hit(rd_dir_hit)
  );

  for (genvar i = 0; i < NP; i++) begin : g_port
    gpio_port_bank #(.W(W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .data_we (wr_en & wr_data_hit[i]),
      .dir_we  (wr_en & wr_dir_hit[i]),
      .wdata   (wr_data),
      .pin_raw (pin_in[i*W +: W]),
      .latch_q (latch_v[i]),
      .dir_q   (dir_v[i]),
      .view    (view_v[i])
    );
    assign pin_out[i*W +: W] = latch_v[i];
    assign pin_oe[i*W +: W]  = dir_v[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NP; i++) begin
      if (rd_data_hit[i]) rd_data = rd_data | view_v[i];
      if (rd_dir_hit[i])  rd_data = rd_data | dir_v[i];
    end
  end
endmodule

// File: rtl/gpio_dual_port_chk.sv
module gpio_dual_port_chk #(
  parameter int ADDR_W    = 8,
  parameter int W         = 8,
  parameter int NUM_PORTS = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      addr,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [W-1:0]           wr_data,
  input logic [W-1:0]           rd_data,
  input logic [NUM_PORTS*W-1:0] pin_out,
  input logic [NUM_PORTS*W-1:0] pin_oe
);
  AST_DIR_CLEARED: assert property (@(posedge clk) rst |=> pin_oe == '0); // R2

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(4)) |=> pin_oe[W-1:0] == $past(wr_data)); // R7

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(0)) |=> pin_out[W-1:0] == $past(wr_data)); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(2)) |=> rd_data == '0); // R8

  AST_OUTPUT_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == ADDR_W'(0) && pin_oe[W-1:0] == '1)
    |=> rd_data == pin_out[W-1:0]); // R5
endmodule

bind gpio_dual_port gpio_dual_port_chk #(
  .ADDR_W(ADDR_W), .W(W), .NUM_PORTS(NUM_PORTS)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_dual_port_bench.sv
module gpio_dual_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_dual_port u_gpio_dual_port (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Behavioural reference model
  logic [7:0]  m_lat [2];
  logic [7:0]  m_dir [2];
  bit   [7:0]  m_known [2];
  logic [7:0]  m_raddr = 8'h00;
  logic [15:0] pin_hist [$] = '{16'h0, 16'h0};

  initial begin
    m_dir[0] = 0; m_dir[1] = 0; m_known[0] = 0; m_known[1] = 0;
    m_lat[0] = 0; m_lat[1] = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_dir[0] = 0; m_dir[1] = 0; m_raddr = 0;
      pin_hist = '{16'h0, 16'h0};
    end else begin
      if (wr_en) begin
        case (addr)
          8'h00: begin m_lat[0] = wr_data; m_known[0] = 8'hFF; end
          8'h01: begin m_lat[1] = wr_data; m_known[1] = 8'hFF; end
          8'h04: m_dir[0] = wr_data;
          8'h05: m_dir[1] = wr_data;
          default: ;
        endcase
      end
      if (rd_en) m_raddr = addr;
      pin_hist.push_back(pin_in);
      void'(pin_hist.pop_front());
    end
  end

  function automatic logic [7:0] model_rd();
    logic [15:0] s = pin_hist[0];
    case (m_raddr)
      8'h00: return (m_dir[0] & m_lat[0]) | (~m_dir[0] & s[7:0]);
      8'h01: return (m_dir[1] & m_lat[1]) | (~m_dir[1] & s[15:8]);
      8'h04: return m_dir[0];
      8'h05: return m_dir[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Every-cycle comparison (R1, R5, R10)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 oe", pin_oe, {m_dir[1], m_dir[0]});
      chk("R1 out", pin_out & {m_known[1], m_known[0]},
          {m_lat[1] & m_known[1], m_lat[0] & m_known[0]});
      if ((m_raddr > 8'h01 || m_known[m_raddr[0]] == 8'hFF ||
           m_dir[m_raddr[0]] == 8'h00))
        chk("R10 rd", {8'h0, rd_data}, {8'h0, model_rd()});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R2 oe", pin_oe, 16'h0);
    chk("R2 rd", {8'h0, rd_data}, 16'h0);

    pin_in = 16'hA5C3;
    wr(8'h00, 8'h3C);
    chk("R4 out", {8'h0, pin_out[7:0]}, 16'h003C);
    chk("R4 oe", pin_oe, 16'h0);

    wr(8'h04, 8'hF0);
    rd(8'h00);
    chk("R5 mix", {8'h0, rd_data}, 16'h0033);
    rd(8'h04);
    chk("R7 dirA", {8'h0, rd_data}, 16'h00F0);

    wr(8'h01, 8'h99);
    wr(8'h05, 8'hFF);
    rd(8'h01);
    chk("R9 portB", {8'h0, rd_data}, 16'h0099);
    chk("R9 oe", pin_oe, 16'hFFF0);
    rd(8'h05);
    chk("R7 dirB", {8'h0, rd_data}, 16'h00FF);

    // R6 synchronizer latency with held read address
    wr(8'h04, 8'h00);
    rd(8'h00);
    chk("R6 before", {8'h0, rd_data}, 16'h00C3);
    pin_in[7:0] = 8'h5E;
    @(negedge clk);
    chk("R6 one edge", {8'h0, rd_data}, 16'h00C3);
    @(negedge clk);
    chk("R6 two edges", {8'h0, rd_data}, 16'h005E);

    // R8 unmapped
    rd(8'h02);
    chk("R8 rd", {8'h0, rd_data}, 16'h0);
    wr(8'h07, 8'hFF);
    wr(8'h03, 8'hAA);
    chk("R8 oe", pin_oe, 16'hFF00);
    chk("R8 out", pin_out, 16'h993C);

    // R10 held address follows latch
    wr(8'h04, 8'hFF);
    rd(8'h00);
    chk("R10 a", {8'h0, rd_data}, 16'h003C);
    wr(8'h00, 8'h11);
    chk("R10 follow", {8'h0, rd_data}, 16'h0011);

    // R3 latch survives reset
    wr(8'h00, 8'h5A);
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R3 out", pin_out, 16'h995A);
    chk("R2 oe after", pin_oe, 16'h0);

    // Random phase against the model
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      case ($urandom_range(0, 5))
        0: a = 8'h00; 1: a = 8'h01; 2: a = 8'h04; 3: a = 8'h05;
        default: a = 8'($urandom_range(0, 9));
      endcase
      pin_in = 16'($urandom);
      addr = a; wr_data = 8'($urandom);
      wr_en = $urandom_range(0, 1) == 1;
      rd_en = $urandom_range(0, 1) == 1;
      @(negedge clk);
    end
    wr_en = 0; rd_en = 0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule